// File: doc/BRIEF.md
# Local Interrupt Acceptance and Prioritizer

This block sits beside a CPU core and takes interrupt messages from a system interrupt router. Each message names a vector, a delivery mode, a destination, a destination mode and a trigger type. The block keeps only the messages that are addressed to its own ID and that use a maskable delivery mode. It queues each such vector in a 256-entry request array and records whether the source is level- or edge-triggered. Messages with an unmaskable mode are flagged as unsupported and dropped.

Two registers hold the highest pending request vector and the vector currently in service. An interrupt-pending line goes to the CPU when three things hold: the pending vector outranks the in-service vector, interrupts are enabled, and the vector's priority class is above the task-priority class. When the CPU acknowledges, the block returns the winning vector in the same cycle and moves it from the request array to the in-service array.

The message input is a valid/ready stream. Ready is always high, so the block never applies back-pressure: every cycle with valid high transfers exactly one message.

Top module: `intr_accept_top`

## Requirements
- R1: `msg_ready_o` is always 1. A message transfers in any cycle with `msg_valid_i` high. The fields are: destination in bits 7:0, vector in bits 15:8, delivery mode in bits 18:16, destination mode in bit 19 (0 = physical, 1 = logical), level in bit 20 and trigger in bit 21 (1 = level, 0 = edge).
- R2: In physical mode a message is addressed to the block only when the destination equals `local_id_i`. In logical mode it is addressed only when `local_id_i` is below 8 and destination bit `local_id_i` is 1. Messages that are not addressed have no effect.
- R3: Delivery modes 0 and 1 are maskable and are queued. Modes 2, 4, 5 and 7 are unmaskable: they are not queued, and `unsup_o` is 1 in the same cycle as an addressed message that uses them. Modes 3 and 6 are neither queued nor flagged.
- R4: An accepted vector whose request bit is already set is ignored, including its trigger bit. Otherwise the request bit is set and the trigger bit is stored. `ack_trig_o` returns the stored trigger bit with the acknowledged vector.
- R5: `pending_o` is 1 only when all three hold: the highest request vector is greater than the in-service vector, `ie_i` is 1, and bits 7:4 of the highest request vector are greater than bits 7:4 of `tpr_i`. Bits 3:0 of `tpr_i` have no effect.
- R6: An acknowledge taken while `pending_o` is 1 drives the highest request vector on `ack_vec_o` in that cycle. From the next cycle that vector is the in-service vector and its request bit is cleared. An acknowledge while `pending_o` is 0 is ignored, and `ack_vec_o` and `ack_trig_o` stay 0.
- R7: The highest request vector is always the highest set request bit, or 0 when no request bit is set. It is raised when a larger vector arrives and recomputed after an acknowledge.
- R8: If a message and an acknowledge arrive in the same cycle, the acknowledge is applied first and the message second. The following cycle reflects both.
- R9: After reset the request, in-service and trigger arrays and both tracking registers are 0, so `pending_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_id_i | input | 8 | ID of this block |
| msg_valid_i | input | 1 | Message valid |
| msg_ready_o | output | 1 | Message ready, always 1 |
| msg_data_i | input | 22 | Message word |
| tpr_i | input | 8 | Task priority; bits 7:4 are the class |
| ie_i | input | 1 | CPU interrupt-enable flag |
| pending_o | output | 1 | Interrupt pending to the CPU |
| ack_i | input | 1 | CPU acknowledge strobe |
| ack_vec_o | output | 8 | Acknowledged vector, valid with a taken acknowledge |
| ack_trig_o | output | 1 | Trigger type of the acknowledged vector |
| unsup_o | output | 1 | Addressed message uses an unmaskable mode |

## Verification
The assertions assume at most one message per cycle and treat `ack_i` as a strobe that may arrive at any time, including when nothing is pending. They also assume that `tpr_i` and `ie_i` may change between any two cycles. The in-service array is expected to change only on a taken acknowledge, because the block has no end-of-interrupt path. The stimulus changes inputs only on falling edges and resets between sweep points so that each case starts from empty arrays. Because the in-service vector only grows, each sequence acknowledges vectors in ascending order.

// File: rtl/intr_accept_pkg.sv
package intr_accept_pkg;
  localparam int VEC_W     = 8;
  localparam int DST_W     = 8;
  localparam int ID_W      = 8;
  localparam int MSG_W     = 22;
  localparam int WORD_W    = 32;
  localparam int CLS_W     = 4;
  localparam int DM_W      = 3;
  localparam int DST_LSB   = 0;
  localparam int VEC_LSB   = 8;
  localparam int DM_LSB    = 16;
  localparam int DMODE_BIT = 19;
  localparam int LVL_BIT   = 20;
  localparam int TRIG_BIT  = 21;

  typedef enum logic [DM_W-1:0] {
    DLV_FIXED  = 3'd0,
    DLV_LOWEST = 3'd1,
    DLV_SMI    = 3'd2,
    DLV_RSV3   = 3'd3,
    DLV_NMI    = 3'd4,
    DLV_INIT   = 3'd5,
    DLV_RSV6   = 3'd6,
    DLV_EXTINT = 3'd7
  } dlv_mode_e;

  function automatic logic dlv_maskable(dlv_mode_e m);
    return (m == DLV_FIXED) || (m == DLV_LOWEST);
  endfunction

  function automatic logic dlv_unmaskable(dlv_mode_e m);
    return (m == DLV_SMI) || (m == DLV_NMI) || (m == DLV_INIT) || (m == DLV_EXTINT);
  endfunction
endpackage

// File: rtl/intr_msg_decode.sv
module intr_msg_decode
  import intr_accept_pkg::*;
#(
  parameter int P_MSG_W = MSG_W,
  parameter int P_VEC_W = VEC_W,
  parameter int P_DST_W = DST_W,
  parameter int P_ID_W  = ID_W
) (
  input  logic               msg_valid_i,
  input  logic [P_MSG_W-1:0] msg_data_i,
  input  logic [P_ID_W-1:0]  local_id_i,
  output logic               acc_valid_o,
  output logic [P_VEC_W-1:0] acc_vec_o,
  output logic               acc_trig_o,
  output logic               unsup_o
);
  localparam int DSEL_W = $clog2(P_DST_W);

  logic [P_DST_W-1:0] dst;
  dlv_mode_e          mode;
  logic               logical;
  logic               hit;
  logic               unused_lvl;

  assign dst        = msg_data_i[DST_LSB +: P_DST_W];
  assign acc_vec_o  = msg_data_i[VEC_LSB +: P_VEC_W];
  assign mode       = dlv_mode_e'(msg_data_i[DM_LSB +: DM_W]);
  assign logical    = msg_data_i[DMODE_BIT];
  assign acc_trig_o = msg_data_i[TRIG_BIT];
  assign unused_lvl = msg_data_i[LVL_BIT];

  always_comb begin
    hit = 1'b0;
    if (!logical) begin
      hit = (32'(dst) == 32'(local_id_i));
    end else if (32'(local_id_i) < P_DST_W) begin
      hit = dst[local_id_i[DSEL_W-1:0]];
    end
  end

  assign acc_valid_o = msg_valid_i && hit && dlv_maskable(mode);
  assign unsup_o     = msg_valid_i && hit && dlv_unmaskable(mode);
endmodule

// File: rtl/intr_prio_enc.sv
module intr_prio_enc #(
  parameter int WIDTH = 256,
  parameter int WORD  = 32,
  parameter int IDX_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int NWORD = WIDTH / WORD;
  localparam int OFF_W = $clog2(WORD);

  logic [NWORD-1:0]       word_any;
  logic [NWORD*OFF_W-1:0] word_idx;

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    logic [OFF_W-1:0] loc;
    always_comb begin
      loc = '0;
      for (int b = 0; b < WORD; b++) begin
        if (bits_i[w*WORD + b]) loc = OFF_W'(b);
      end
    end
    assign word_any[w]                  = |bits_i[w*WORD +: WORD];
    assign word_idx[w*OFF_W +: OFF_W]   = loc;
  end

  always_comb begin
    idx_o = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (word_any[w]) idx_o = IDX_W'(w*WORD + int'(word_idx[w*OFF_W +: OFF_W]));
    end
  end
endmodule

// File: rtl/intr_vec_store.sv
module intr_vec_store #(
  parameter int P_VEC_W  = 8,
  parameter int P_WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ack_take_i,
  input  logic                     acc_valid_i,
  input  logic [P_VEC_W-1:0]       acc_vec_i,
  input  logic                     acc_trig_i,
  output logic [(1<<P_VEC_W)-1:0]  irr_q,
  output logic [(1<<P_VEC_W)-1:0]  isr_q,
  output logic [P_VEC_W-1:0]       irrv_q,
  output logic [P_VEC_W-1:0]       isrv_q,
  output logic                     top_trig_o
);
  localparam int NVEC = 1 << P_VEC_W;

  logic [NVEC-1:0]    irr_n, isr_n, tmr_n, tmr_q;
  logic [P_VEC_W-1:0] irrv_n, isrv_n;

  always_comb begin
    irr_n  = irr_q;
    isr_n  = isr_q;
    tmr_n  = tmr_q;
    isrv_n = isrv_q;
    if (ack_take_i) begin
      irr_n[irrv_q] = 1'b0;
      isr_n[irrv_q] = 1'b1;
      isrv_n        = irrv_q;
    end
    if (acc_valid_i && !irr_n[acc_vec_i]) begin
      irr_n[acc_vec_i] = 1'b1;
      tmr_n[acc_vec_i] = acc_trig_i;
    end
  end

  intr_prio_enc #(.WIDTH(NVEC), .WORD(P_WORD_W), .IDX_W(P_VEC_W)) enc_i (
    .bits_i (irr_n),
    .idx_o  (irrv_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      tmr_q  <= '0;
      irrv_q <= '0;
      isrv_q <= '0;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      tmr_q  <= tmr_n;
      irrv_q <= irrv_n;
      isrv_q <= isrv_n;
    end
  end

  assign top_trig_o = tmr_q[irrv_q];
endmodule

// File: rtl/intr_accept_top.sv
module intr_accept_top
  import intr_accept_pkg::*;
#(
  parameter int P_VEC_W  = VEC_W,
  parameter int P_DST_W  = DST_W,
  parameter int P_ID_W   = ID_W,
  parameter int P_MSG_W  = MSG_W,
  parameter int P_WORD_W = WORD_W,
  parameter int P_CLS_W  = CLS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P_ID_W-1:0]  local_id_i,
  input  logic               msg_valid_i,
  output logic               msg_ready_o,
  input  logic [P_MSG_W-1:0] msg_data_i,
  input  logic [P_VEC_W-1:0] tpr_i,
  input  logic               ie_i,
  output logic               pending_o,
  input  logic               ack_i,
  output logic [P_VEC_W-1:0] ack_vec_o,
  output logic               ack_trig_o,
  output logic               unsup_o
);
  localparam int NVEC = 1 << P_VEC_W;

  logic               acc_valid, acc_trig, ack_take, top_trig;
  logic [P_VEC_W-1:0] acc_vec, irrv_q, isrv_q;
  logic [NVEC-1:0]    irr_q, isr_q;

  assign msg_ready_o = 1'b1;

  intr_msg_decode #(
    .P_MSG_W(P_MSG_W), .P_VEC_W(P_VEC_W), .P_DST_W(P_DST_W), .P_ID_W(P_ID_W)
  ) dec_i (
    .msg_valid_i (msg_valid_i),
    .msg_data_i  (msg_data_i),
    .local_id_i  (local_id_i),
    .acc_valid_o (acc_valid),
    .acc_vec_o   (acc_vec),
    .acc_trig_o  (acc_trig),
    .unsup_o     (unsup_o)
  );

  intr_vec_store #(.P_VEC_W(P_VEC_W), .P_WORD_W(P_WORD_W)) store_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_take_i  (ack_take),
    .acc_valid_i (acc_valid),
    .acc_vec_i   (acc_vec),
    .acc_trig_i  (acc_trig),
    .irr_q       (irr_q),
    .isr_q       (isr_q),
    .irrv_q      (irrv_q),
    .isrv_q      (isrv_q),
    .top_trig_o  (top_trig)
  );

  assign pending_o = (irrv_q > isrv_q) && ie_i &&
                     (irrv_q[P_VEC_W-1 -: P_CLS_W] > tpr_i[P_VEC_W-1 -: P_CLS_W]);
  assign ack_take   = ack_i && pending_o;
  assign ack_vec_o  = ack_take ? irrv_q : '0;
  assign ack_trig_o = ack_take && top_trig;
endmodule

// File: rtl/intr_accept_chk.sv
module intr_accept_chk #(
  parameter int P_VEC_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ack_i,
  input logic                    ie_i,
  input logic                    pending_o,
  input logic                    unsup_o,
  input logic [P_VEC_W-1:0]      ack_vec_o,
  input logic [(1<<P_VEC_W)-1:0] irr_q,
  input logic [(1<<P_VEC_W)-1:0] isr_q,
  input logic [P_VEC_W-1:0]      irrv_q,
  input logic [P_VEC_W-1:0]      isrv_q
);
  localparam int NVEC = 1 << P_VEC_W;

  AST_IRRV_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_q >> irrv_q) <= NVEC'(1)) && (irr_q == '0 || irr_q[irrv_q])); // R7

  AST_PEND_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o |-> (ie_i && irr_q != '0)); // R5

  AST_ACK_TO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && pending_o) |=> (isrv_q == $past(ack_vec_o)) && isr_q[$past(ack_vec_o)]); // R6

  AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !pending_o) |=> $stable(isr_q) && $stable(isrv_q)); // R6

  AST_UNSUP_NOT_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (unsup_o && !ack_i) |=> $stable(irr_q)); // R3
endmodule

bind intr_accept_top intr_accept_chk #(.P_VEC_W(P_VEC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ack_i     (ack_i),
  .ie_i      (ie_i),
  .pending_o (pending_o),
  .unsup_o   (unsup_o),
  .ack_vec_o (ack_vec_o),
  .irr_q     (irr_q),
  .isr_q     (isr_q),
  .irrv_q    (irrv_q),
  .isrv_q    (isrv_q)
);

// File: tb/intr_accept_top_tb_top.sv
module intr_accept_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  local_id = 8'd5;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic [21:0] msg_data = '0;
  logic [7:0]  tpr = 8'h00;
  logic        ie = 1'b1;
  logic        pending;
  logic        ack = 1'b0;
  logic [7:0]  ack_vec;
  logic        ack_trig;
  logic        unsup;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  intr_accept_top dut_i (
    .clk(clk), .rst_n(rst_n), .local_id_i(local_id), .msg_valid_i(msg_valid),
    .msg_ready_o(msg_ready), .msg_data_i(msg_data), .tpr_i(tpr), .ie_i(ie),
    .pending_o(pending), .ack_i(ack), .ack_vec_o(ack_vec), .ack_trig_o(ack_trig),
    .unsup_o(unsup)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; msg_valid = 1'b0; ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic addressed(logic [7:0] dst, logic logical);
    if (!logical) return dst == local_id;
    return (local_id < 8) && dst[local_id[2:0]];
  endfunction

  // Drive one message for one cycle; unsup_o checked while it is presented.
  task automatic send(logic [7:0] dst, logic [7:0] vec, logic [2:0] dm,
                      logic logical, logic trig);
    logic exp_u;
    msg_data  = {trig, 1'b0, logical, dm, vec, dst};
    msg_valid = 1'b1;
    exp_u = addressed(dst, logical) &&
            (dm == 3'd2 || dm == 3'd4 || dm == 3'd5 || dm == 3'd7);
    #1 chk("R3 unsupported flag", 32'(unsup), 32'(exp_u));
    tick();
    msg_valid = 1'b0;
  endtask

  task automatic do_ack(logic [7:0] exp_vec, logic exp_trig);
    ack = 1'b1;
    #1;
    chk("R6 ack vector", 32'(ack_vec), 32'(exp_vec));
    chk("R4 ack trigger", 32'(ack_trig), 32'(exp_trig));
    tick();
    ack = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    // R9 reset state, R1 ready
    do_reset();
    chk("R9 pending after reset", 32'(pending), 32'd0);
    chk("R1 ready high", 32'(msg_ready), 32'd1);
    ack = 1'b1; #1;
    chk("R6 ack ignored when idle", 32'(ack_vec), 32'd0);
    chk("R7 empty gives no pending", 32'(pending), 32'd0);
    tick(); ack = 1'b0;

    // R3 delivery mode sweep
    do_reset();
    for (int m = 0; m < 8; m++) send(8'd5, 8'(8'h20 + m*16), 3'(m), 1'b0, 1'b0);
    chk("R3 maskable queued", 32'(pending), 32'd1);
    do_ack(8'h30, 1'b0);
    chk("R5 lower than in-service", 32'(pending), 32'd0);

    // R2 destination sweep over ids, modes, all destinations
    foreach (local_id_list[i]) begin end
    for (int k = 0; k < 4; k++) begin
      local_id = (k == 0) ? 8'd0 : (k == 1) ? 8'd3 : (k == 2) ? 8'd7 : 8'd9;
      for (int lg = 0; lg < 2; lg++) begin
        for (int d = 0; d < 256; d++) begin
          do_reset();
          send(8'(d), 8'h80, 3'd0, 1'(lg), 1'b0);
          chk("R2 address match", 32'(pending), 32'(addressed(8'(d), 1'(lg))));
        end
      end
    end
    local_id = 8'd5;

    // R4 duplicate ignored, trigger recorded
    do_reset();
    send(8'd5, 8'h66, 3'd1, 1'b0, 1'b0);
    send(8'd5, 8'h66, 3'd0, 1'b0, 1'b1);
    do_ack(8'h66, 1'b0);
    send(8'd5, 8'h77, 3'd0, 1'b0, 1'b1);
    do_ack(8'h77, 1'b1);

    // R5 task-priority class sweep
    for (int tc = 0; tc < 16; tc++) begin
      for (int vc = 0; vc < 16; vc++) begin
        do_reset();
        tpr = {4'(tc), 4'hF};
        send(8'd5, {4'(vc), 4'h5}, 3'd0, 1'b0, 1'b0);
        chk("R5 class compare", 32'(pending), 32'(vc > tc));
      end
    end
    tpr = 8'h00;

    // R5/R6 enable flag and ignored acknowledge
    do_reset();
    ie = 1'b0;
    send(8'd5, 8'h90, 3'd0, 1'b0, 1'b0);
    chk("R5 disabled", 32'(pending), 32'd0);
    do_ack(8'h00, 1'b0);
    ie = 1'b1; #1;
    chk("R6 ignored ack left request", 32'(pending), 32'd1);
    do_ack(8'h90, 1'b0);

    // R7 highest of arbitrary arrival order, then recompute
    do_reset();
    send(8'd5, 8'h25, 3'd0, 1'b0, 1'b0);
    send(8'd5, 8'hE0, 3'd0, 1'b0, 1'b0);
    send(8'd5, 8'hD0, 3'd0, 1'b0, 1'b0);
    do_ack(8'hE0, 1'b0);
    chk("R7 remaining below in-service", 32'(pending), 32'd0);
    send(8'd5, 8'hE8, 3'd0, 1'b0, 1'b0);
    do_ack(8'hE8, 1'b0);

    // R7 pair sweep: encoder picks the larger of two vectors
    for (int v = 0; v < 256; v++) begin
      do_reset();
      send(8'd5, 8'(v), 3'd0, 1'b0, 1'b0);
      send(8'd5, 8'(255 - v), 3'd1, 1'b0, 1'b0);
      do_ack((v > 127) ? 8'(v) : 8'(255 - v), 1'b0);
    end

    // R8 message and acknowledge in the same cycle
    do_reset();
    send(8'd5, 8'h60, 3'd0, 1'b0, 1'b0);
    msg_data  = {1'b0, 1'b0, 1'b0, 3'd0, 8'hA0, 8'd5};
    msg_valid = 1'b1;
    ack       = 1'b1;
    #1 chk("R8 ack wins current top", 32'(ack_vec), 32'h60);
    tick();
    msg_valid = 1'b0; ack = 1'b0;
    chk("R8 message applied too", 32'(pending), 32'd1);
    do_ack(8'hA0, 1'b0);

    done = 1'b1;
    report();
  end

  byte local_id_list [1];
endmodule